// File: doc/BRIEF.md
# Multi-Slot DRAM Command Sequencer

This block plays back a short, programmable script of DRAM commands. The script is used for memory training and testing. It has up to four command slots. Each slot fires its own RAS/CAS/WE pattern a configured number of times, and each issue carries a data-direction tag. A slot can put a gap of empty cycles between its own issues and an idle stretch after its last issue, before the next slot begins. Slots always run in ascending order, from slot 0 to a programmed last slot. That run is one pass.

A pass count sets how many times the whole script runs. Writing a non-zero count starts the machine. The count is decremented after each pass, and the all-ones code means the script repeats until software writes zero. An optional wait window follows every pass. An error strobe from an external data checker can halt the run, and it can also latch a trigger pin for a logic analyser. A four-bit status word reports idle, busy, done and halted-on-error.

Configuration goes through a plain write port: addresses 0 to 3 hold the slot words and address 4 holds the sequence control word.

Top module: `dram_cmd_seq`

## Requirements
- R1: After reset, status is 4'b0001 (idle only), cmd_valid is 0, trig_o is 0 and the three command lines are high.
- R2: A control write (address 4) with a non-zero pass count in bits [7:0] starts the run. The first command appears in the second cycle after the write edge. From that cycle on, status shows busy with done and error cleared. cmd_valid is never high while the block is not busy.
- R3: A slot word carries a repetition count in bits [8:0] and a gap in bits [13:9]. A repetition count R issues R+1 commands, and consecutive issues within the slot are separated by exactly G empty cycles.
- R4: A slot word carries an idle count I in bits [22:14]. After a slot's last issue, I empty cycles pass before the next slot's first issue. Slots run 0,1,... up to the last-slot index in control bits [19:18], and slots beyond that index are never issued.
- R5: While cmd_valid is high, {cmd_we_n,cmd_cas_n,cmd_ras_n} equals slot-word bits [27:25] and cmd_dir equals slot-word bits [24:23] (00 none, 01 read, 10 write, 11 both). cmd_slot names the slot being issued. Otherwise the command lines are all high.
- R6: A pass count N runs N full passes. A wait count W in control bits [16:8] adds W empty cycles after every pass, the last one included. Then status becomes 4'b0101 (idle and done).
- R7: A pass count of 8'hFF repeats the script with no decrement. A control write with a zero pass count while busy aborts at that edge. No further commands are issued and status becomes 4'b0101.
- R8: With stop-on-error (control bit 17) set, an err_in pulse while busy halts the run at that edge. Status becomes 4'b1001 (idle and error) and no further commands are issued.
- R9: With stop-on-error clear, err_in has no effect on the command schedule or on the error status bit.
- R10: With the trigger enable (control bit 20) set, trig_o rises on the first err_in seen while busy and stays high until the next run starts. With the enable clear, trig_o stays low.
- R11: Status bit 0 is idle, bit 1 busy, bit 2 done and bit 3 error. Exactly one of idle and busy is set at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | 0..3 slot word, 4 control word |
| cfg_wdata | input | 28 | Configuration write data |
| err_in | input | 1 | Error pulse from the data checker |
| cmd_valid | output | 1 | A command is issued this cycle |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_dir | output | 2 | Data direction of the issued command |
| cmd_slot | output | 2 | Slot index being issued |
| status | output | 4 | {error, done, busy, idle} |
| trig_o | output | 1 | Sticky first-error trigger |

## Verification
The hardest case to reach from the ports is the endless mode: the run has to go on beyond 255 passes to show that no decrement happens. The bench uses a one-command slot with a single idle cycle, so 300 commands pass in a few hundred cycles, and then aborts with a zero write. A second hard case is a halt part-way through a long slot. An error pulse is timed against a known issue cycle, and the bench then checks that the halted state, the error bit and the sticky trigger all hold. A restart that follows must clear them.

// File: rtl/dram_cmd_seq.sv
module dram_cmd_seq #(
  parameter int REP_W  = 9,
  parameter int GAP_W  = 5,
  parameter int IDL_W  = 9,
  parameter int ITER_W = 8,
  parameter int WAIT_W = 9,
  localparam int CFG_W = REP_W + GAP_W + IDL_W + 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             err_in,
  output logic             cmd_valid,
  output logic             cmd_ras_n,
  output logic             cmd_cas_n,
  output logic             cmd_we_n,
  output logic [1:0]       cmd_dir,
  output logic [1:0]       cmd_slot,
  output logic [3:0]       status,
  output logic             trig_o
);

  localparam int GAP_LO  = REP_W;
  localparam int IDL_LO  = GAP_LO + GAP_W;
  localparam int DIR_LO  = IDL_LO + IDL_W;
  localparam int CMD_LO  = DIR_LO + 2;
  localparam int WT_LO   = ITER_W;
  localparam int STOP_B  = WT_LO + WAIT_W;
  localparam int LAST_LO = STOP_B + 1;
  localparam int TRIG_B  = LAST_LO + 2;
  localparam int M1      = (IDL_W > WAIT_W) ? IDL_W : WAIT_W;
  localparam int CNT_W   = (M1 > GAP_W) ? M1 : GAP_W;
  localparam logic [ITER_W-1:0] FOREVER = '1;

  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_GAP, S_SIDLE, S_WAIT} st_t;

  st_t                st, st_n;
  logic [CFG_W-1:0]   slot_cfg [4];
  logic [1:0]         slot, slot_n, last_q;
  logic [REP_W-1:0]   rep, rep_n;
  logic [CNT_W-1:0]   cnt, cnt_n;
  logic [ITER_W-1:0]  it_q, it_n;
  logic [WAIT_W-1:0]  wait_q;
  logic               stop_en, trig_en;
  logic               done_q, err_q, trig_q;
  logic               sfin, ifin, fin_ev;

  wire [CFG_W-1:0] cur     = slot_cfg[slot];
  wire [REP_W-1:0] cur_rep = cur[REP_W-1:0];
  wire [GAP_W-1:0] cur_gap = cur[GAP_LO +: GAP_W];
  wire [IDL_W-1:0] cur_idl = cur[IDL_LO +: IDL_W];

  wire busy   = (st != S_IDLE);
  wire ctl_wr = cfg_we && (cfg_addr == 3'd4);
  wire abort  = ctl_wr && (cfg_wdata[ITER_W-1:0] == '0) && busy;
  wire halt   = busy && err_in && stop_en;
  wire start  = !busy && (it_q != '0);

  always_comb begin
    st_n   = st;
    slot_n = slot;
    rep_n  = rep;
    cnt_n  = cnt;
    it_n   = it_q;
    sfin   = 1'b0;
    ifin   = 1'b0;
    fin_ev = 1'b0;
    case (st)
      S_IDLE: if (start) begin
        st_n   = S_ISSUE;
        slot_n = 2'd0;
        rep_n  = '0;
      end
      S_ISSUE: begin
        if (rep == cur_rep) begin
          rep_n = '0;
          if (cur_idl != '0) begin
            st_n  = S_SIDLE;
            cnt_n = CNT_W'(cur_idl);
          end else sfin = 1'b1;
        end else begin
          rep_n = rep + 1'b1;
          if (cur_gap != '0) begin
            st_n  = S_GAP;
            cnt_n = CNT_W'(cur_gap);
          end
        end
      end
      S_GAP:   if (cnt == CNT_W'(1)) st_n = S_ISSUE; else cnt_n = cnt - CNT_W'(1);
      S_SIDLE: if (cnt == CNT_W'(1)) sfin = 1'b1;    else cnt_n = cnt - CNT_W'(1);
      S_WAIT:  if (cnt == CNT_W'(1)) ifin = 1'b1;    else cnt_n = cnt - CNT_W'(1);
      default: st_n = S_IDLE;
    endcase
    if (sfin) begin
      if (slot == last_q) begin
        if (wait_q != '0) begin
          st_n  = S_WAIT;
          cnt_n = CNT_W'(wait_q);
        end else ifin = 1'b1;
      end else begin
        slot_n = slot + 2'd1;
        st_n   = S_ISSUE;
      end
    end
    if (ifin) begin
      slot_n = 2'd0;
      if (it_q == FOREVER) st_n = S_ISSUE;
      else if (it_q == ITER_W'(1)) begin
        it_n   = '0;
        st_n   = S_IDLE;
        fin_ev = 1'b1;
      end else begin
        it_n = it_q - ITER_W'(1);
        st_n = S_ISSUE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      slot    <= '0;
      rep     <= '0;
      cnt     <= '0;
      it_q    <= '0;
      wait_q  <= '0;
      last_q  <= '0;
      stop_en <= 1'b0;
      trig_en <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      trig_q  <= 1'b0;
      for (int i = 0; i < 4; i++) slot_cfg[i] <= '0;
    end else begin
      if (cfg_we && cfg_addr < 3'd4) slot_cfg[cfg_addr[1:0]] <= cfg_wdata;
      if (ctl_wr) begin
        wait_q  <= cfg_wdata[WT_LO +: WAIT_W];
        stop_en <= cfg_wdata[STOP_B];
        last_q  <= cfg_wdata[LAST_LO +: 2];
        trig_en <= cfg_wdata[TRIG_B];
      end
      if (trig_en && busy && err_in) trig_q <= 1'b1;
      if (abort) begin
        st     <= S_IDLE;
        it_q   <= '0;
        done_q <= 1'b1;
      end else if (halt) begin
        st    <= S_IDLE;
        it_q  <= '0;
        err_q <= 1'b1;
      end else begin
        st   <= st_n;
        slot <= slot_n;
        rep  <= rep_n;
        cnt  <= cnt_n;
        it_q <= ctl_wr ? cfg_wdata[ITER_W-1:0] : it_n;
        if (start) begin
          done_q <= 1'b0;
          err_q  <= 1'b0;
          trig_q <= 1'b0;
        end
        if (fin_ev) done_q <= 1'b1;
      end
    end
  end

  assign cmd_valid = (st == S_ISSUE);
  assign {cmd_we_n, cmd_cas_n, cmd_ras_n} = cmd_valid ? cur[CMD_LO +: 3] : 3'b111;
  assign cmd_dir  = cmd_valid ? cur[DIR_LO +: 2] : 2'b00;
  assign cmd_slot = slot;
  assign status   = {err_q, done_q, busy, !busy};
  assign trig_o   = trig_q;

endmodule

// File: rtl/dram_cmd_seq_chk.sv
module dram_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic [2:0] cfg_addr,
  input logic       err_in,
  input logic       cmd_valid,
  input logic [3:0] status,
  input logic       trig_o,
  input logic       stop_en
);

  // R11
  idle_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(status[1:0]) == 1);

  // R2
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[1] && status[2]));

  // R2
  cmd_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> status[1]);

  // R8
  halt_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_en && status[1] && err_in && !(cfg_we && cfg_addr == 3'd4))
      |=> (!status[1] && status[3] && !cmd_valid));

  // R9
  no_stop_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_en && status[1] && !status[3] && err_in) |=> !status[3]);

  // R10
  trig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_o && status[1]) |=> trig_o);

endmodule

bind dram_cmd_seq dram_cmd_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .err_in(err_in), .cmd_valid(cmd_valid), .status(status),
  .trig_o(trig_o), .stop_en(stop_en)
);

// File: tb/dram_cmd_seq_tb.sv
`timescale 1ns/1ps
module dram_cmd_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [27:0] cfg_wdata = '0;
  logic        err_in = 1'b0;
  logic        cmd_valid, cmd_ras_n, cmd_cas_n, cmd_we_n, trig_o;
  logic [1:0]  cmd_dir, cmd_slot;
  logic [3:0]  status;

  always #2 clk = ~clk;

  dram_cmd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .err_in(err_in), .cmd_valid(cmd_valid),
    .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n),
    .cmd_dir(cmd_dir), .cmd_slot(cmd_slot), .status(status), .trig_o(trig_o)
  );

  int errs = 0, checks = 0;
  int m_rep[4], m_gap[4], m_idl[4], m_dir[4], m_cmd[4];
  int m_last, m_wait, m_stop, m_trig;
  int ex_t[600], ex_s[600];
  int ex_n, ex_done;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 28'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic int ctl_word(input int iter);
    return iter | (m_wait << 8) | (m_stop << 17) | (m_last << 18) | (m_trig << 20);
  endfunction

  task automatic load_slots();
    for (int i = 0; i < 4; i++)
      wr(i, m_rep[i] | (m_gap[i] << 9) | (m_idl[i] << 14) | (m_dir[i] << 23) | (m_cmd[i] << 25));
  endtask

  task automatic build(input int iters);
    int t = 1;
    ex_n = 0;
    for (int it = 0; it < iters; it++) begin
      for (int s = 0; s <= m_last; s++)
        for (int r = 0; r <= m_rep[s]; r++) begin
          ex_t[ex_n] = t; ex_s[ex_n] = s; ex_n++;
          t += 1 + ((r < m_rep[s]) ? m_gap[s] : m_idl[s]);
        end
      t += m_wait;
    end
    ex_done = t;
  endtask

  task automatic collect(input string req, input int limit);
    int n = 0, bad = 0, end_k = -1;
    for (int k = 0; k < limit; k++) begin
      if (k == 1) chk(status == 4'b0010, "R2", "status after start", status, 2);
      if (k > 0 && status[0]) begin end_k = k; break; end
      if (cmd_valid) begin
        if (n < ex_n) begin
          chk(k == ex_t[n], req, "issue cycle", k, ex_t[n]);
          chk(cmd_slot == 2'(ex_s[n]), "R4", "slot order", cmd_slot, ex_s[n]);
          chk({cmd_we_n, cmd_cas_n, cmd_ras_n} == 3'(m_cmd[ex_s[n]]), "R5", "cmd lines",
              {cmd_we_n, cmd_cas_n, cmd_ras_n}, m_cmd[ex_s[n]]);
          chk(cmd_dir == 2'(m_dir[ex_s[n]]), "R5", "direction", cmd_dir, m_dir[ex_s[n]]);
        end
        n++;
      end else if ({cmd_we_n, cmd_cas_n, cmd_ras_n} != 3'b111) bad++;
      @(negedge clk);
    end
    chk(n == ex_n, req, "command count", n, ex_n);
    chk(end_k == ex_done, "R6", "completion cycle", end_k, ex_done);
    chk(bad == 0, "R5", "inactive lines high", bad, 0);
    chk(status == 4'b0101, "R6", "final status", status, 5);
  endtask

  task automatic clear_cfg();
    for (int i = 0; i < 4; i++) begin
      m_rep[i] = 0; m_gap[i] = 0; m_idl[i] = 0; m_dir[i] = 0; m_cmd[i] = 7;
    end
    m_last = 0; m_wait = 0; m_stop = 0; m_trig = 0;
  endtask

  task automatic t_reset();
    chk(status == 4'b0001, "R1", "reset status", status, 1);
    chk(cmd_valid == 1'b0, "R1", "reset cmd_valid", cmd_valid, 0);
    chk(trig_o == 1'b0, "R1", "reset trigger", trig_o, 0);
    chk({cmd_we_n, cmd_cas_n, cmd_ras_n} == 3'b111, "R1", "reset lines", {cmd_we_n, cmd_cas_n, cmd_ras_n}, 7);
  endtask

  task automatic t_single();
    clear_cfg();
    m_rep[0] = 2; m_gap[0] = 3; m_dir[0] = 1; m_cmd[0] = 3'b110;
    load_slots(); build(1);
    wr(4, ctl_word(1));
    collect("R3", 200);
  endtask

  task automatic t_multi();
    clear_cfg();
    m_rep[0] = 1; m_idl[0] = 2; m_dir[0] = 2; m_cmd[0] = 3'b010;
    m_rep[1] = 0; m_gap[1] = 7; m_dir[1] = 3; m_cmd[1] = 3'b001;
    m_rep[2] = 3; m_gap[2] = 1; m_idl[2] = 1; m_dir[2] = 0; m_cmd[2] = 3'b100;
    m_rep[3] = 5; m_cmd[3] = 3'b000;
    m_last = 2; m_wait = 4;
    load_slots(); build(3);
    wr(4, ctl_word(3));
    collect("R6", 400);
  endtask

  task automatic t_all_slots();
    clear_cfg();
    for (int i = 0; i < 4; i++) begin m_cmd[i] = i; m_dir[i] = 3 - i; end
    m_last = 3;
    load_slots(); build(2);
    wr(4, ctl_word(2));
    collect("R4", 100);
  endtask

  task automatic t_forever();
    int n = 0, late = 0;
    clear_cfg();
    m_idl[0] = 1; m_cmd[0] = 3'b011;
    load_slots();
    wr(4, ctl_word(255));
    for (int k = 0; k < 600; k++) begin
      if (cmd_valid) n++;
      @(negedge clk);
    end
    chk(n == 300, "R7", "endless command count", n, 300);
    chk(status[1] == 1'b1, "R7", "still busy past 255 passes", status[1], 1);
    wr(4, ctl_word(0));
    chk(status == 4'b0101, "R7", "status after abort", status, 5);
    for (int k = 0; k < 6; k++) begin
      if (cmd_valid) late++;
      @(negedge clk);
    end
    chk(late == 0, "R7", "commands after abort", late, 0);
  endtask

  task automatic t_err_nostop();
    clear_cfg();
    m_rep[0] = 9; m_gap[0] = 1; m_dir[0] = 2; m_cmd[0] = 3'b101;
    load_slots(); build(1);
    wr(4, ctl_word(1));
    fork
      collect("R9", 200);
      begin
        repeat (5) @(negedge clk);
        err_in = 1'b1;
        @(negedge clk);
        err_in = 1'b0;
      end
    join
    chk(status[3] == 1'b0, "R9", "error bit without stop", status[3], 0);
    chk(trig_o == 1'b0, "R10", "trigger disabled stays low", trig_o, 0);
  endtask

  task automatic t_err_stop();
    int late = 0;
    clear_cfg();
    m_rep[0] = 50; m_cmd[0] = 3'b110; m_stop = 1; m_trig = 1;
    load_slots();
    wr(4, ctl_word(1));
    repeat (3) @(negedge clk);
    chk(cmd_valid == 1'b1, "R8", "running before error", cmd_valid, 1);
    err_in = 1'b1;
    @(negedge clk);
    err_in = 1'b0;
    chk(status == 4'b1001, "R8", "status after halt", status, 9);
    chk(trig_o == 1'b1, "R10", "trigger on first error", trig_o, 1);
    for (int k = 0; k < 5; k++) begin
      if (cmd_valid) late++;
      @(negedge clk);
    end
    chk(late == 0, "R8", "commands after halt", late, 0);
    chk(trig_o == 1'b1, "R10", "trigger held", trig_o, 1);
    chk(status == 4'b1001, "R8", "halt status held", status, 9);
    m_rep[0] = 1; m_stop = 0; m_trig = 0;
    load_slots(); build(1);
    wr(4, ctl_word(1));
    collect("R2", 100);
    chk(trig_o == 1'b0, "R10", "trigger cleared by new run", trig_o, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_multi();
    t_all_slots();
    t_forever();
    t_err_nostop();
    t_err_stop();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule